// File: doc/BRIEF.md
# Converter Bring-Up and Resynchronization Sequencer

This controller walks a high-speed data converter from power-up to live transmission. It waits for a power-good input to stay high for a settling window. It then pulses the converter's active-low reset and issues a fixed, ordered schedule of masked register writes to an external serial-interface master over a request/acknowledge port. Each write carries an address, a bit mask and data, and the master changes only the masked bits. Partway through the schedule the controller sends a single one-cycle pulse on its sync output. It then waits a fixed number of idle cycles to cover clock-domain crossing latency. It finishes by writing the sync sources back to harmless values and raising transmit-enable.

Two static mode inputs shape the schedule. With `pll_mode` set, the N-divider sync enable is switched on before the pulse and off after it. With `dual_sync` set, the clock-divider sync enable stays on; otherwise it is cleared before transmission. If a clock-lost or FIFO-collision alarm arrives while transmitting, transmit-enable drops in the same cycle. The schedule then resumes at the first sync-configuration write, without another reset pulse. If the master fails to acknowledge a write within a bounded time, the controller stops in a sticky error state.

States: `S_IDLE` (waiting for power-good), `S_SETTLE` (power-good settling window), `S_RESET` (reset pulse), `S_WRITE` (one register write outstanding), `S_PULSE` (sync pulse), `S_GAP` (idle cycles after the pulse), `S_RUN` (transmitting), `S_ERR` (acknowledge timeout). Transitions:
- IDLE→SETTLE when power-good is high.
- SETTLE→IDLE when power-good falls; SETTLE→RESET when the window ends.
- RESET→WRITE at step 0.
- WRITE→WRITE on acknowledge when the next step is in the same section.
- WRITE→PULSE on acknowledge of the last write before the pulse.
- WRITE→RUN on acknowledge of the last write.
- WRITE→ERR on timeout.
- PULSE→GAP.
- GAP→WRITE at the first sync-disable step.
- RUN→WRITE at the first sync-configuration step on an alarm.

Top module: `conv_bringup_seq`

## Requirements
- R1: During and after `rst_n` low, until `pwr_good` is seen high, the outputs are idle: `tx_en`, `wr_req`, `sync_out`, `done`, `busy` and `err` are 0, and `conv_rst_n` is 1.
- R2: `pwr_good` must be high for `SETTLE_CYC` consecutive cycles, with `busy` high during that window, before the reset pulse. If it falls during the window, the block returns to idle without pulsing `conv_rst_n`.
- R3: `conv_rst_n` is driven low for exactly RST_CYC = ceil(`RST_MIN_PS`/`CLK_PERIOD_PS`) cycles (2 cycles at 20 ns for a 25 ns minimum), and no write is requested while it is low.
- R4: A write transfers in a cycle where `wr_req` and `wr_ack` are both 1. Until then, `wr_req`, `wr_addr`, `wr_mask` and `wr_data` hold steady. The next write, if any, is requested in the following cycle. `wr_ack` while `wr_req` is 0 has no effect.
- R5: The first three writes, as (address, mask, data) in hex, are (1, 0100, 0000), (16, 3000, 3000) and (27, 0800, 0800).
- R6: The sync-configuration writes follow in this order:
  - (32, F000, `fifo_in_sel`<<12)
  - (32, 0F00, `fifo_out_sel`<<8)
  - (31, 000C, `fmt_sel`<<2)
  - (32, 0001, `cdiv_sel`)
  - (0, 0004, 0004)
- R7: With `pll_mode`=1, (24, 0800, 0800) is written after the R6 writes, and (24, 0800, 0000) is the final write after the pulse. With `pll_mode`=0, neither is written.
- R8: After the last pre-pulse write is acknowledged, `sync_out` is 1 for exactly one cycle. `SYNC_GAP` cycles with no request and `busy`=1 follow.
- R9: After the gap, the writes (32, F000, 0000), (32, 0F00, 0000) and (31, 000C, 0008) are issued. With `dual_sync`=0 they are followed by (0, 0004, 0000); with `dual_sync`=1 that write is skipped.
- R10: The cycle after the final write is acknowledged, `tx_en` and `done` are 1 and `busy` is 0. They stay so until an alarm or a reset.
- R11: In the run state, either alarm forces `tx_en` to 0 in the same cycle. The next cycle requests the first R6 write, with no reset pulse and none of the R5 writes.
- R12: If `wr_ack` does not arrive within `ACK_TIMEOUT` cycles of a request, `err` goes to 1. `err` stays 1, with `wr_req`, `tx_en` and `busy` at 0, until `rst_n` is asserted.
- R13: Alarms have no effect outside the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supplies are up |
| pll_mode | input | 1 | Converter clocked through its PLL (static) |
| dual_sync | input | 1 | Dual sync-source mode (static) |
| fifo_in_sel | input | 4 | FIFO input-pointer sync source code |
| fifo_out_sel | input | 4 | FIFO output-pointer sync source code |
| fmt_sel | input | 2 | Data-formatter sync source code |
| cdiv_sel | input | 1 | Clock-divider sync source code |
| alarm_clk_lost | input | 1 | A converter clock has been lost |
| alarm_fifo_coll | input | 1 | FIFO pointer collision alarm |
| wr_req | output | 1 | Register write requested |
| wr_addr | output | 6 | Register address |
| wr_mask | output | 16 | Bits of the register to change |
| wr_data | output | 16 | New values for the masked bits |
| wr_ack | input | 1 | Serial master accepted the write |
| conv_rst_n | output | 1 | Converter reset, active low |
| tx_en | output | 1 | Converter transmit enable |
| sync_out | output | 1 | Sync pulse to the converter |
| done | output | 1 | Sequence complete, transmitting |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Sticky acknowledge-timeout error |

## Verification
The bench replays each mode combination against a schedule it builds from the requirements. It acknowledges writes with varying latency, so a design that advanced on a stale acknowledge, or let the request drop early, would skip or repeat a write. It injects a power-good drop during settling, which catches a design that pulses reset anyway. It raises alarms and stray acknowledges during the post-pulse gap, where a design that reacted would restart or shorten the gap. It raises an alarm while transmitting, where a design that restarted from reset or left transmit-enable high for a cycle would show the wrong outputs. It withholds an acknowledge to prove the timeout fires after exactly the parameterized window and that the error is not cleared by later activity.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 16;
    localparam int STEP_W  = 4;
    localparam int N_STEPS = 14;

    // Step indices whose position matters to the sequencing
    localparam logic [STEP_W-1:0] STEP_FIRST    = 4'd0;
    localparam logic [STEP_W-1:0] STEP_RESYNC   = 4'd3;
    localparam logic [STEP_W-1:0] STEP_LAST_PRE = 4'd8;
    localparam logic [STEP_W-1:0] STEP_END      = 4'd14;

    typedef enum logic [2:0] {
        S_IDLE, S_SETTLE, S_RESET, S_WRITE, S_PULSE, S_GAP, S_RUN, S_ERR
    } state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } wr_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Whether a schedule step is issued for the given modes
    function automatic logic step_used(input logic [STEP_W-1:0] s,
                                       input logic pll, input logic dual);
        logic r;
        case (s)
            4'd8, 4'd13: r = pll;
            4'd12:       r = ~dual;
            default:     r = (int'(s) < N_STEPS);
        endcase
        return r;
    endfunction

    // First issued step after s, or STEP_END
    function automatic logic [STEP_W-1:0] step_after(input logic [STEP_W-1:0] s,
                                                     input logic pll, input logic dual);
        logic [STEP_W-1:0] r;
        r = STEP_END;
        for (int k = N_STEPS - 1; k >= 0; k--) begin
            if (k > int'(s) && step_used(STEP_W'(k), pll, dual))
                r = STEP_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/cbs_timer.sv
module cbs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cbs_step_rom.sv
module cbs_step_rom
    import cbs_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [3:0]        fifo_in_sel,
    input  logic [3:0]        fifo_out_sel,
    input  logic [1:0]        fmt_sel,
    input  logic              cdiv_sel,
    output wr_t               ent
);

    always_comb begin
        ent = '0;
        case (step)
            // initial housekeeping writes
            4'd0:  ent = '{addr: 6'd1,  mask: 16'h0100, data: 16'h0000};
            4'd1:  ent = '{addr: 6'd16, mask: 16'h3000, data: 16'h3000};
            4'd2:  ent = '{addr: 6'd27, mask: 16'h0800, data: 16'h0800};
            // sync configuration (resync entry point)
            4'd3:  ent = '{addr: 6'd32, mask: 16'hF000, data: {fifo_in_sel, 12'h000}};
            4'd4:  ent = '{addr: 6'd32, mask: 16'h0F00, data: {4'h0, fifo_out_sel, 8'h00}};
            4'd5:  ent = '{addr: 6'd31, mask: 16'h000C, data: {12'h000, fmt_sel, 2'b00}};
            4'd6:  ent = '{addr: 6'd32, mask: 16'h0001, data: {15'h0000, cdiv_sel}};
            4'd7:  ent = '{addr: 6'd0,  mask: 16'h0004, data: 16'h0004};
            4'd8:  ent = '{addr: 6'd24, mask: 16'h0800, data: 16'h0800};
            // sync disable after the pulse
            4'd9:  ent = '{addr: 6'd32, mask: 16'hF000, data: 16'h0000};
            4'd10: ent = '{addr: 6'd32, mask: 16'h0F00, data: 16'h0000};
            4'd11: ent = '{addr: 6'd31, mask: 16'h000C, data: 16'h0008};
            4'd12: ent = '{addr: 6'd0,  mask: 16'h0004, data: 16'h0000};
            4'd13: ent = '{addr: 6'd24, mask: 16'h0800, data: 16'h0000};
            default: ent = '0;
        endcase
    end

endmodule

// File: rtl/conv_bringup_seq.sv
module conv_bringup_seq
    import cbs_pkg::*;
#(
    parameter int SETTLE_CYC    = 16,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int RST_MIN_PS    = 25000,
    parameter int ACK_TIMEOUT   = 64,
    parameter int SYNC_GAP      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              pll_mode,
    input  logic              dual_sync,
    input  logic [3:0]        fifo_in_sel,
    input  logic [3:0]        fifo_out_sel,
    input  logic [1:0]        fmt_sel,
    input  logic              cdiv_sel,
    input  logic              alarm_clk_lost,
    input  logic              alarm_fifo_coll,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              conv_rst_n,
    output logic              tx_en,
    output logic              sync_out,
    output logic              done,
    output logic              busy,
    output logic              err
);

    localparam int RST_RAW = (RST_MIN_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
    localparam int MAX_CYC = imax(imax(SETTLE_CYC, RST_CYC), imax(ACK_TIMEOUT, SYNC_GAP));
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    localparam logic [TMR_W-1:0] LD_SETTLE = TMR_W'(SETTLE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_RESET  = TMR_W'(RST_CYC - 1);
    localparam logic [TMR_W-1:0] LD_ACK    = TMR_W'(ACK_TIMEOUT - 1);
    localparam logic [TMR_W-1:0] LD_GAP    = TMR_W'(SYNC_GAP - 1);

    state_t            state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              alarm_any;
    wr_t               cur;

    assign alarm_any = alarm_clk_lost | alarm_fifo_coll;

    cbs_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cbs_step_rom u_rom (
        .step         (step_q),
        .fifo_in_sel  (fifo_in_sel),
        .fifo_out_sel (fifo_out_sel),
        .fmt_sel      (fmt_sel),
        .cdiv_sel     (cdiv_sel),
        .ent          (cur)
    );

    // Next-state and timer control
    always_comb begin
        logic [STEP_W-1:0] nxt;
        state_d  = state_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        nxt      = step_after(step_q, pll_mode, dual_sync);
        unique case (state_q)
            S_IDLE: begin
                if (pwr_good) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETTLE;
                end
            end
            S_SETTLE: begin
                if (!pwr_good) begin
                    state_d = S_IDLE;
                end else if (tmr_zero) begin
                    state_d  = S_RESET;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RESET;
                end
            end
            S_RESET: begin
                if (tmr_zero) begin
                    state_d  = S_WRITE;
                    step_d   = STEP_FIRST;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACK;
                end
            end
            S_WRITE: begin
                if (wr_ack) begin
                    if (step_q <= STEP_LAST_PRE && nxt > STEP_LAST_PRE) begin
                        state_d = S_PULSE;
                        step_d  = nxt;
                    end else if (nxt == STEP_END) begin
                        state_d = S_RUN;
                    end else begin
                        step_d   = nxt;
                        tmr_load = 1'b1;
                        tmr_val  = LD_ACK;
                    end
                end else if (tmr_zero) begin
                    state_d = S_ERR;
                end
            end
            S_PULSE: begin
                state_d  = S_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_GAP;
            end
            S_GAP: begin
                if (tmr_zero) begin
                    state_d  = S_WRITE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACK;
                end
            end
            S_RUN: begin
                if (alarm_any) begin
                    state_d  = S_WRITE;
                    step_d   = STEP_RESYNC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACK;
                end
            end
            S_ERR: begin
                state_d = S_ERR;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= STEP_FIRST;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Outputs
    always_comb begin
        wr_req     = (state_q == S_WRITE);
        wr_addr    = cur.addr;
        wr_mask    = cur.mask;
        wr_data    = cur.data;
        conv_rst_n = (state_q != S_RESET);
        sync_out   = (state_q == S_PULSE);
        tx_en      = (state_q == S_RUN) && !alarm_any;
        done       = (state_q == S_RUN);
        err        = (state_q == S_ERR);
        busy       = !(state_q inside {S_IDLE, S_RUN, S_ERR});
    end

endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
    parameter int RST_CYC = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        alarm_clk_lost,
    input logic        alarm_fifo_coll,
    input logic        wr_req,
    input logic [5:0]  wr_addr,
    input logic [15:0] wr_mask,
    input logic [15:0] wr_data,
    input logic        wr_ack,
    input logic        conv_rst_n,
    input logic        tx_en,
    input logic        sync_out,
    input logic        done,
    input logic        busy,
    input logic        err
);

    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= 0;
        else if (conv_rst_n)
            low_cnt <= 0;
        else
            low_cnt <= low_cnt + 1;
    end

    // R3: reset pulse long enough
    a_r3_rst_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_rst_n) |-> low_cnt >= RST_CYC);

    // R3: no write while the converter is held in reset
    a_r3_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> conv_rst_n);

    // R4: request and payload held until acknowledged
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> err ||
            (wr_req && $stable(wr_addr) && $stable(wr_mask) && $stable(wr_data)));

    // R8: the sync pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R8: no write during the pulse
    a_r8_pulse_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> !wr_req && busy);

    // R10: transmit only once the sequence is complete
    a_r10_tx_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> done && !busy && !err);

    // R11: an alarm in the run state blocks transmit at once and restarts writes
    a_r11_alarm_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
        done && (alarm_clk_lost || alarm_fifo_coll) |-> !tx_en);

    a_r11_alarm_resync: assert property (@(posedge clk) disable iff (!rst_n)
        done && (alarm_clk_lost || alarm_fifo_coll) |=> wr_req && conv_rst_n && !done);

    // R12: error is sticky and quiet
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && !wr_req && !tx_en && !busy);

endmodule

bind conv_bringup_seq cbs_checker #(.RST_CYC(RST_CYC)) u_cbs_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .alarm_clk_lost  (alarm_clk_lost),
    .alarm_fifo_coll (alarm_fifo_coll),
    .wr_req          (wr_req),
    .wr_addr         (wr_addr),
    .wr_mask         (wr_mask),
    .wr_data         (wr_data),
    .wr_ack          (wr_ack),
    .conv_rst_n      (conv_rst_n),
    .tx_en           (tx_en),
    .sync_out        (sync_out),
    .done            (done),
    .busy            (busy),
    .err             (err)
);

// File: tb/conv_bringup_seq_tb_top.sv
module conv_bringup_seq_tb_top;

    localparam int SETTLE = 4;
    localparam int TO     = 8;
    localparam int GAP    = 3;
    localparam int PER_PS = 20000;
    localparam int RMIN   = 25000;
    localparam int RSTC   = (RMIN + PER_PS - 1) / PER_PS;

    logic        clk = 1'b0;
    logic        rst_n, pwr_good, pll_mode, dual_sync, cdiv_sel;
    logic [3:0]  fifo_in_sel, fifo_out_sel;
    logic [1:0]  fmt_sel;
    logic        alarm_clk_lost, alarm_fifo_coll, wr_ack;
    logic        wr_req, conv_rst_n, tx_en, sync_out, done, busy, err;
    logic [5:0]  wr_addr;
    logic [15:0] wr_mask, wr_data;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    conv_bringup_seq #(
        .SETTLE_CYC(SETTLE), .CLK_PERIOD_PS(PER_PS), .RST_MIN_PS(RMIN),
        .ACK_TIMEOUT(TO), .SYNC_GAP(GAP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pll_mode(pll_mode),
        .dual_sync(dual_sync), .fifo_in_sel(fifo_in_sel), .fifo_out_sel(fifo_out_sel),
        .fmt_sel(fmt_sel), .cdiv_sel(cdiv_sel), .alarm_clk_lost(alarm_clk_lost),
        .alarm_fifo_coll(alarm_fifo_coll), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_mask(wr_mask), .wr_data(wr_data), .wr_ack(wr_ack), .conv_rst_n(conv_rst_n),
        .tx_en(tx_en), .sync_out(sync_out), .done(done), .busy(busy), .err(err)
    );

    typedef struct {
        logic [5:0]  a;
        logic [15:0] m;
        logic [15:0] d;
        string       tag;
    } wexp_t;

    wexp_t sched[$];

    task automatic chk(input string tag, input logic req, input logic [5:0] a,
                       input logic [15:0] m, input logic [15:0] d, input logic rn,
                       input logic tx, input logic sy, input logic dn,
                       input logic bs, input logic er);
        logic bad;
        n_chk++;
        bad = (wr_req !== req) || (conv_rst_n !== rn) || (tx_en !== tx) ||
              (sync_out !== sy) || (done !== dn) || (busy !== bs) || (err !== er);
        if (req && (wr_addr !== a || wr_mask !== m || wr_data !== d)) bad = 1'b1;
        if (bad) begin
            n_err++;
            $display("FAIL %s at %0t: actual req=%b a=%0d m=%h d=%h rn=%b tx=%b sy=%b dn=%b bs=%b er=%b expected req=%b a=%0d m=%h d=%h rn=%b tx=%b sy=%b dn=%b bs=%b er=%b",
                     tag, $time, wr_req, wr_addr, wr_mask, wr_data, conv_rst_n, tx_en,
                     sync_out, done, busy, err, req, a, m, d, rn, tx, sy, dn, bs, er);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk(tag, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic quiet_busy_chk(input string tag, input logic rn);
        chk(tag, 0, 0, 0, 0, rn, 0, 0, 0, 1, 0);
    endtask

    task automatic run_chk(input string tag);
        chk(tag, 0, 0, 0, 0, 1, 1, 0, 1, 0, 0);
    endtask

    // Advance to the next sampling point and release one-cycle stimuli
    task automatic tick();
        @(negedge clk);
        wr_ack          = 1'b0;
        alarm_clk_lost  = 1'b0;
        alarm_fifo_coll = 1'b0;
    endtask

    task automatic push(input logic [5:0] a, input logic [15:0] m,
                        input logic [15:0] d, input string tag);
        wexp_t e;
        e.a = a; e.m = m; e.d = d; e.tag = tag;
        sched.push_back(e);
    endtask

    task automatic add_init();
        push(6'd1,  16'h0100, 16'h0000, "R5");
        push(6'd16, 16'h3000, 16'h3000, "R5");
        push(6'd27, 16'h0800, 16'h0800, "R5");
    endtask

    task automatic add_sync_cfg();
        push(6'd32, 16'hF000, {fifo_in_sel, 12'h000}, "R6");
        push(6'd32, 16'h0F00, {4'h0, fifo_out_sel, 8'h00}, "R6");
        push(6'd31, 16'h000C, {12'h000, fmt_sel, 2'b00}, "R6");
        push(6'd32, 16'h0001, {15'h0000, cdiv_sel}, "R6");
        push(6'd0,  16'h0004, 16'h0004, "R6");
        if (pll_mode) push(6'd24, 16'h0800, 16'h0800, "R7");
    endtask

    task automatic add_post();
        push(6'd32, 16'hF000, 16'h0000, "R9");
        push(6'd32, 16'h0F00, 16'h0000, "R9");
        push(6'd31, 16'h000C, 16'h0008, "R9");
        if (!dual_sync) push(6'd0, 16'h0004, 16'h0000, "R9");
        if (pll_mode)   push(6'd24, 16'h0800, 16'h0000, "R7");
    endtask

    // Serve the queued writes; acknowledge latency cycles through 0..lat_mod-1 (R4)
    task automatic drain(input int lat_mod);
        int i;
        i = 0;
        while (sched.size() > 0) begin
            wexp_t e;
            int    lat;
            e   = sched.pop_front();
            lat = i % lat_mod;
            for (int k = 0; k <= lat; k++) begin
                tick();
                chk(e.tag, 1, e.a, e.m, e.d, 1, 0, 0, 0, 1, 0);
                if (k == lat) wr_ack = 1'b1;
            end
            i++;
        end
    endtask

    // R8 pulse and gap; with noise, R13 alarms and R4 stray acks in the gap
    task automatic pulse_gap(input logic noise);
        tick();
        chk("R8", 0, 0, 0, 0, 1, 0, 1, 0, 1, 0);
        for (int g = 0; g < GAP; g++) begin
            tick();
            quiet_busy_chk(noise ? "R13" : "R8", 1'b1);
            if (noise) begin
                wr_ack         = 1'b1;
                alarm_clk_lost = 1'b1;
            end
        end
    endtask

    task automatic sync_section(input int lat_mod, input logic noise);
        add_sync_cfg();
        drain(lat_mod);
        pulse_gap(noise);
        add_post();
        drain(lat_mod);
        tick();
        run_chk("R10");
    endtask

    task automatic full_bringup(input int lat_mod, input logic noise);
        pwr_good = 1'b1;
        repeat (SETTLE) begin tick(); quiet_busy_chk("R2", 1'b1); end
        repeat (RSTC)   begin tick(); quiet_busy_chk("R3", 1'b0); end
        add_init();
        drain(lat_mod);
        sync_section(lat_mod, noise);
    endtask

    // R11: alarm while running; must be called right after a run check
    task automatic alarm_resync(input logic use_coll, input int lat_mod);
        if (use_coll) alarm_fifo_coll = 1'b1;
        else          alarm_clk_lost  = 1'b1;
        #1;
        chk("R11", 0, 0, 0, 0, 1, 0, 0, 1, 0, 0);
        sync_section(lat_mod, 1'b0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired before the run completed");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b0; pll_mode = 1'b0; dual_sync = 1'b0;
        fifo_in_sel = 4'h5; fifo_out_sel = 4'hA; fmt_sel = 2'd1; cdiv_sel = 1'b1;
        alarm_clk_lost = 1'b0; alarm_fifo_coll = 1'b0; wr_ack = 1'b0;

        // R1: reset state and idle after release
        repeat (3) begin tick(); idle_chk("R1"); end
        rst_n = 1'b1;
        repeat (3) begin tick(); idle_chk("R1"); end

        // R2: power-good drop during settling returns to idle, no reset pulse
        pwr_good = 1'b1;
        repeat (2) begin tick(); quiet_busy_chk("R2", 1'b1); end
        pwr_good = 1'b0;
        repeat (3) begin tick(); idle_chk("R2"); end

        // Single-source, no PLL, varied ack latency, noise in the gap
        full_bringup(3, 1'b1);
        repeat (3) begin tick(); run_chk("R10"); end
        alarm_resync(1'b0, 2);
        repeat (2) begin tick(); run_chk("R10"); end

        // Dual-source with PLL
        rst_n = 1'b0; pwr_good = 1'b0;
        tick(); idle_chk("R1");
        pll_mode = 1'b1; dual_sync = 1'b1;
        fifo_in_sel = 4'h3; fifo_out_sel = 4'hC; fmt_sel = 2'd3; cdiv_sel = 1'b0;
        rst_n = 1'b1;
        tick(); idle_chk("R1");
        full_bringup(2, 1'b0);
        repeat (2) begin tick(); run_chk("R10"); end
        alarm_resync(1'b1, 1);
        tick(); run_chk("R10");

        // R12: acknowledge timeout
        rst_n = 1'b0; pwr_good = 1'b0; pll_mode = 1'b0; dual_sync = 1'b0;
        tick(); idle_chk("R1");
        rst_n = 1'b1;
        tick(); idle_chk("R1");
        pwr_good = 1'b1;
        repeat (SETTLE) begin tick(); quiet_busy_chk("R2", 1'b1); end
        repeat (RSTC)   begin tick(); quiet_busy_chk("R3", 1'b0); end
        for (int k = 0; k < TO; k++) begin
            tick();
            chk("R12", 1, 6'd1, 16'h0100, 16'h0000, 1, 0, 0, 0, 1, 0);
        end
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R12", 0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
            wr_ack         = 1'b1;
            alarm_clk_lost = 1'b1;
        end
        rst_n = 1'b0;
        tick(); idle_chk("R12");

        summary();
        $finish;
    end

endmodule